// File: doc/BRIEF.md
# Byte-Wide NOR Flash Command Interface Emulator

This block is a synthesizable, device-side stand-in for the command interface of a byte-wide NOR flash. A host controller under test drives a one-cycle write strobe with an address and a data byte. The block decodes the two-write unlock pattern and the command bytes that follow it. It then runs a program, sector-erase or chip-erase operation against a small internal byte array. The array is split into eight equal sectors, and each operation holds the part busy for a set number of clock cycles.

While an operation runs, reads return a polling status byte instead of array data, so a controller's completion-polling loop can be tested. Once the operation ends, reads return the stored bytes again. The busy times are parameters given in clock cycles, which keeps the long real-device delays down to a few cycles.

Top module: `flash_cmd_emu`

## Requirements
- R1: After reset the block is not busy, the decoder is idle and every array byte reads 8'hFF.
- R2: A command byte is only accepted after two writes: 8'hAA at the first unlock address, then 8'h55 at the second. The first unlock address is 16'h5555 and the second is 16'h2AAA, each cut to the low ADDR_W bits. A write with the wrong address or data at any step sends the decoder back to idle, and the stored data does not change.
- R3: The sequence unlock, then 8'hA0 at the first unlock address, makes the next write a program. The byte at that address becomes its old value ANDed with the written data.
- R4: The sequence unlock, 8'h80 at the first unlock address, unlock again, then 8'h30 at any address erases one sector to 8'hFF. The sector is given by the top three address bits of that last write. Bytes in other sectors keep their values.
- R5: The same erase setup followed by 8'h10 at the first unlock address erases the whole array to 8'hFF. Writing 8'h10 at any other address erases nothing.
- R6: busy_o rises in the cycle after the accepting write. It stays high for exactly PROG_CYC, SECT_CYC or CHIP_CYC cycles, depending on the operation.
- R7: While busy, rdata_o reads {~d7, 7'b0}, where d7 is bit 7 of the programmed data. During an erase it reads 8'h00. When not busy, rdata_o is the array byte at addr_i.
- R8: Writes that arrive while busy are ignored. They change neither the array, the decoder nor the busy length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Write strobe, one cycle per bus write |
| addr_i | input | ADDR_W | Byte address for writes and reads |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Array data, or polling status while busy |
| busy_o | output | 1 | Operation in progress |

## Verification
The bench builds the block with ADDR_W=10, so each sector holds 128 bytes and sector boundaries can be hit with a few addresses. It uses PROG_CYC=8, SECT_CYC=12 and CHIP_CYC=16. These lengths are short enough to count each busy period cycle by cycle. They are still long enough that a complete four-write program sequence fits inside one busy window, which tests that such writes are ignored. With three different lengths, a timer that loads the wrong operation's count shows up as an error.

// File: rtl/flash_emu_pkg.sv
package flash_emu_pkg;
  typedef enum logic [1:0] {OP_PROG, OP_SECT, OP_CHIP} op_e;
  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_CMD, ST_PROG, ST_ERA0, ST_ERA1, ST_ERA2
  } dec_st_e;
  localparam logic [15:0] UNLOCK_A1 = 16'h5555;
  localparam logic [15:0] UNLOCK_A2 = 16'h2AAA;
  localparam logic [7:0]  KEY1      = 8'hAA;
  localparam logic [7:0]  KEY2      = 8'h55;
  localparam logic [7:0]  CMD_PROG  = 8'hA0;
  localparam logic [7:0]  CMD_ERASE = 8'h80;
  localparam logic [7:0]  CMD_SECT  = 8'h30;
  localparam logic [7:0]  CMD_CHIP  = 8'h10;
endpackage

// File: rtl/flash_seq_decoder.sv
module flash_seq_decoder
  import flash_emu_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              busy_i,
  output logic              start_o,
  output op_e               op_o
);
  localparam logic [ADDR_W-1:0] A1 = UNLOCK_A1[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A2 = UNLOCK_A2[ADDR_W-1:0];

  dec_st_e st_q, st_d;
  logic    wr_ok, hit_key1, hit_key2, at_a1;

  assign wr_ok    = wr_i && !busy_i;
  assign at_a1    = addr_i == A1;
  assign hit_key1 = at_a1 && wdata_i == KEY1;
  assign hit_key2 = (addr_i == A2) && wdata_i == KEY2;

  always_comb begin
    st_d    = st_q;
    start_o = 1'b0;
    op_o    = OP_PROG;
    if (wr_ok) begin
      st_d = ST_IDLE;
      unique case (st_q)
        ST_IDLE: if (hit_key1) st_d = ST_UNL1;
        ST_UNL1: if (hit_key2) st_d = ST_CMD;
        ST_CMD: begin
          if (at_a1 && wdata_i == CMD_PROG)       st_d = ST_PROG;
          else if (at_a1 && wdata_i == CMD_ERASE) st_d = ST_ERA0;
        end
        ST_PROG: start_o = 1'b1;
        ST_ERA0: if (hit_key1) st_d = ST_ERA1;
        ST_ERA1: if (hit_key2) st_d = ST_ERA2;
        ST_ERA2: begin
          if (wdata_i == CMD_SECT) begin
            start_o = 1'b1;
            op_o    = OP_SECT;
          end else if (at_a1 && wdata_i == CMD_CHIP) begin
            start_o = 1'b1;
            op_o    = OP_CHIP;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;

  assert_mismatch_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !busy_i && st_q == ST_UNL1 && !hit_key2) |=> st_q == ST_IDLE);
  assert_no_start_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !start_o);
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer
  import flash_emu_pkg::*;
#(
  parameter int PROG_CYC = 8,
  parameter int SECT_CYC = 12,
  parameter int CHIP_CYC = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  op_e        op_i,
  input  logic [7:0] wdata_i,
  output logic       busy_o,
  output logic       poll_o
);
  localparam int MAX_PE  = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAX_CYC = (MAX_PE > CHIP_CYC) ? MAX_PE : CHIP_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q, load_val;
  logic             poll_q;

  always_comb
    unique case (op_i)
      OP_SECT: load_val = CNT_W'(SECT_CYC);
      OP_CHIP: load_val = CNT_W'(CHIP_CYC);
      default: load_val = CNT_W'(PROG_CYC);
    endcase

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q  <= '0;
      poll_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= load_val;
      poll_q <= (op_i == OP_PROG) ? ~wdata_i[7] : 1'b0; // erase target is FFh
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - 1'b1;
    end

  assign busy_o = cnt_q != '0;
  assign poll_o = poll_q;

  assert_start_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  assert_busy_drops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !start_i && cnt_q == CNT_W'(1)) |=> !busy_o);
endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array
  import flash_emu_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int SECTORS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int SECT_W = $clog2(SECTORS);

  logic [7:0]        mem_q [DEPTH];
  logic [SECT_W-1:0] tgt_sect;

  assign tgt_sect = addr_i[ADDR_W-1 -: SECT_W];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (start_i) begin
      unique case (op_i)
        OP_PROG: mem_q[addr_i] <= mem_q[addr_i] & wdata_i;
        OP_SECT:
          for (int i = 0; i < DEPTH; i++)
            if (i[ADDR_W-1 -: SECT_W] == tgt_sect) mem_q[i] <= 8'hFF;
        OP_CHIP:
          for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        default: ;
      endcase
    end

  assign rdata_o = mem_q[addr_i];

  assert_chip_erase_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == OP_CHIP) |=> (mem_q[0] == 8'hFF && mem_q[DEPTH-1] == 8'hFF));
  assert_prog_clears_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == OP_PROG) |=> (rdata_o & ~$past(rdata_o)) == 8'h00 || $past(addr_i) != addr_i);
endmodule

// File: rtl/flash_cmd_emu.sv
module flash_cmd_emu
  import flash_emu_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int SECTORS  = 8,
  parameter int PROG_CYC = 8,
  parameter int SECT_CYC = 12,
  parameter int CHIP_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              busy_o
);
  logic       start;
  op_e        op;
  logic       poll;
  logic [7:0] arr_data;

  flash_seq_decoder #(.ADDR_W(ADDR_W)) u_dec (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .busy_i(busy_o), .start_o(start), .op_o(op)
  );

  flash_busy_timer #(.PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)) u_tmr (
    .clk_i, .rst_ni, .start_i(start), .op_i(op), .wdata_i,
    .busy_o, .poll_o(poll)
  );

  flash_byte_array #(.ADDR_W(ADDR_W), .SECTORS(SECTORS)) u_arr (
    .clk_i, .rst_ni, .start_i(start), .op_i(op), .addr_i, .wdata_i,
    .rdata_o(arr_data)
  );

  assign rdata_o = busy_o ? {poll, 7'b0} : arr_data;

  assert_status_low_bits_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> rdata_o[6:0] == 7'b0);
endmodule

// File: tb/tb_flash_cmd_emu.sv
module tb_flash_cmd_emu;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;
  localparam int PROG_CYC = 8, SECT_CYC = 12, CHIP_CYC = 16;
  localparam logic [ADDR_W-1:0] A1 = 10'h155, A2 = 10'h2AA;

  logic clk = 0, rst_n = 0, wr = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic busy;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_emu #(.ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC),
                  .CHIP_CYC(CHIP_CYC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .busy_o(busy));

  // kind(2) addr(10) data(8) status_during_busy(8) readback(8)
  localparam logic [35:0] VEC [6] = '{
    {2'd0, 10'h010, 8'h5A, 8'h80, 8'h5A},
    {2'd0, 10'h010, 8'hF0, 8'h00, 8'h50},
    {2'd0, 10'h090, 8'h33, 8'h80, 8'h33},
    {2'd1, 10'h000, 8'h30, 8'h00, 8'hFF},
    {2'd0, 10'h3FF, 8'h92, 8'h00, 8'h92},
    {2'd2, 10'h3FF, 8'h10, 8'h00, 8'hFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the following negedge
  task automatic wr1(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic unlock();
    wr1(A1, 8'hAA); wr1(A2, 8'h55);
  endtask

  task automatic issue(input int kind, input logic [ADDR_W-1:0] a, input logic [7:0] d);
    unlock();
    if (kind == 0) begin
      wr1(A1, 8'hA0); wr1(a, d);
    end else begin
      wr1(A1, 8'h80); unlock();
      wr1(kind == 2 ? A1 : a, kind == 2 ? 8'h10 : 8'h30);
    end
  endtask

  function automatic int dur(input int kind);
    return kind == 0 ? PROG_CYC : (kind == 1 ? SECT_CYC : CHIP_CYC);
  endfunction

  task automatic rd(input string req, input logic [ADDR_W-1:0] a, input logic [7:0] exp);
    addr = a; #1;
    chk(req, rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 busy", busy, 0);
    rd("R1 erased 000", 10'h000, 8'hFF);
    rd("R1 erased 3FF", 10'h3FF, 8'hFF);

    foreach (VEC[i]) begin
      automatic int k = int'(VEC[i][35:34]);
      automatic logic [ADDR_W-1:0] a = VEC[i][33:24];
      issue(k, a, VEC[i][23:16]);
      addr = a; #1;
      chk("R6 busy rises", busy, 1);
      chk("R7 status", rdata, VEC[i][15:8]);
      repeat (dur(k) - 1) @(negedge clk);
      chk("R6 busy held", busy, 1);
      @(negedge clk);
      chk("R6 busy ends", busy, 0);
      rd(k == 0 ? "R3 program" : (k == 1 ? "R4 sector erase" : "R5 chip erase"), a, VEC[i][7:0]);
    end

    // R4: only the addressed sector is erased
    issue(0, 10'h100, 8'h0F); repeat (PROG_CYC) @(negedge clk);
    issue(0, 10'h180, 8'h77); repeat (PROG_CYC) @(negedge clk);
    issue(1, 10'h140, 8'h30); repeat (SECT_CYC) @(negedge clk);
    rd("R4 sector 2 erased", 10'h100, 8'hFF);
    rd("R4 sector 3 kept", 10'h180, 8'h77);

    // R2: wrong second unlock address
    wr1(A1, 8'hAA); wr1(10'h2AB, 8'h55); wr1(A1, 8'hA0); wr1(10'h180, 8'h00);
    chk("R2 bad addr no busy", busy, 0);
    rd("R2 bad addr no program", 10'h180, 8'h77);
    // R2: wrong unlock data
    wr1(A1, 8'hAA); wr1(A2, 8'h54); wr1(A1, 8'hA0); wr1(10'h180, 8'h00);
    chk("R2 bad data no busy", busy, 0);
    rd("R2 bad data no program", 10'h180, 8'h77);

    // R5: chip-erase code at a non-unlock address does nothing
    unlock(); wr1(A1, 8'h80); unlock(); wr1(10'h180, 8'h10);
    chk("R5 bad chip erase no busy", busy, 0);
    rd("R5 bad chip erase kept", 10'h180, 8'h77);

    // R8: full program sequence during busy is ignored
    issue(0, 10'h030, 8'h81);
    unlock(); wr1(A1, 8'hA0); wr1(10'h180, 8'h00);
    repeat (PROG_CYC - 4 - 1) @(negedge clk);
    chk("R8 busy length kept", busy, 1);
    @(negedge clk);
    chk("R8 busy ends on time", busy, 0);
    rd("R8 ignored write", 10'h180, 8'h77);
    rd("R3 program during-busy target", 10'h030, 8'h81);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule